// File: doc/BRIEF.md
# Timer Software Event Generator

This block is a compact timer core: a programmable prescaler feeds a 16-bit counter that runs up, down or in center-aligned fashion against an auto-reload limit. A single capture/compare channel sits beside it and works either as an input-capture register or as an output-compare register. Software can force four kinds of event through a write-only strobe word: a counter update, a channel capture/compare, a complementary-control update and a break. Each event bit is acted on in the clock where the word is written and needs no clearing, because nothing is stored.

Every forced event leaves a sticky flag in a status word and produces a single-clock pulse on its own event output. Software clears a flag by writing 0 to its bit; writing 1 leaves it alone. The update flag and the channel flag drive gated interrupt and DMA request lines. A forced update restarts the counter in a direction-dependent way and clears the prescaler's phase while keeping its ratio. In input mode, a forced capture behaves exactly like a real capture, including the overcapture indication.

Top module: `tmr_evgen_top`

## Requirements
- R1: In the strobe word, bit 0 forces an update, bit 1 forces a channel capture/compare, bit 5 forces a control update and bit 7 forces a break. An event takes effect at the clock edge that samples the write, and its event output is high for exactly the following cycle.
- R2: Strobe bits written as 0, and the unused strobe bits (4:2, 6 and 15:8), change no counter value, no capture register, no flag and no pulse.
- R3: On a forced update the counter loads the auto-reload value in down mode (mode code 1) and is cleared to 0 in up mode (code 0) or center mode (code 2). Center mode then resumes counting upward.
- R4: A forced update zeroes the prescaler phase without changing the division value, so the first counter step comes after div+1 enabled cycles.
- R5: Any update, forced or natural, sets status bit 0. The update interrupt line equals status bit 0 ANDed with the update interrupt enable.
- R6: When a forced update falls in the same cycle as a natural wrap, only one update pulse is produced and the counter takes the forced value.
- R7: Natural counting works as follows. Up mode goes from the reload value to 0. Down mode goes from 0 to the reload value. Center mode reverses at the reload value and at 0. Each of these turning points is an update.
- R8: In input mode, a forced channel event copies the current counter value into the capture register and sets status bit 1.
- R9: In input mode, a forced capture that arrives while status bit 1 is already set also sets the overcapture flag, status bit 9.
- R10: In output mode, a forced channel event sets status bit 1 and leaves the compare register and the counter unchanged.
- R11: The channel interrupt line is status bit 1 ANDed with the channel interrupt enable. The channel DMA line is status bit 1 ANDed with the channel DMA enable.
- R12: A forced control update and a forced break each pulse their event output and set status bit 5 and status bit 7, respectively.
- R13: A status write clears each flag whose bit is written as 0 and leaves flags written as 1 alone. An event that sets a flag in the same cycle as a clearing write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Counter enable |
| psc_div_i | input | 16 | Prescaler division minus one |
| arr_i | input | 16 | Auto-reload value |
| cnt_mode_i | input | 2 | 0 up, 1 down, 2 center |
| cc1_in_mode_i | input | 1 | 1 = input capture, 0 = output compare |
| ccr_wr_i | input | 1 | Write strobe for the compare register |
| ccr_wdata_i | input | 16 | Compare register write data |
| evg_wr_i | input | 1 | Event strobe word write |
| evg_wdata_i | input | 16 | Event strobe word data |
| sts_wr_i | input | 1 | Status write (0 bits clear) |
| sts_wdata_i | input | 16 | Status write data |
| uie_i | input | 1 | Update interrupt enable |
| cc1_ie_i | input | 1 | Channel interrupt enable |
| cc1_de_i | input | 1 | Channel DMA enable |
| cnt_o | output | 16 | Counter value |
| ccr_o | output | 16 | Capture/compare register |
| sts_o | output | 16 | Status flags (bits 0,1,5,7,9) |
| upd_irq_o | output | 1 | Update interrupt request |
| cc1_irq_o | output | 1 | Channel interrupt request |
| cc1_dma_o | output | 1 | Channel DMA request |
| upd_evt_o | output | 1 | Update event pulse |
| cc1_evt_o | output | 1 | Channel event pulse |
| com_evt_o | output | 1 | Control update pulse |
| brk_evt_o | output | 1 | Break pulse |

## Verification
Two pairs of functions can meet in one cycle: a forced update and a natural counter turn-around, and a flag-setting event and a flag-clearing status write. For the first pair, the bench brings a center-mode counter to its top value and forces an update in the very cycle the reversal would happen. It passes only if one pulse appears and the counter reads 0 and then counts upward, which tells it apart from the natural result, the reload value minus one. For the second pair, the bench issues a break in the same cycle as a write that clears every flag and expects only the break flag to survive.

// File: rtl/tmr_evgen_pkg.sv
package tmr_evgen_pkg;
    typedef enum logic [1:0] {
        CNT_UP     = 2'd0,
        CNT_DOWN   = 2'd1,
        CNT_CENTER = 2'd2
    } cnt_mode_e;

    // strobe word bit positions
    localparam int EV_UPD = 0;
    localparam int EV_CC1 = 1;
    localparam int EV_COM = 5;
    localparam int EV_BRK = 7;

    // status word bit positions
    localparam int ST_UIF   = 0;
    localparam int ST_CC1IF = 1;
    localparam int ST_COMIF = 5;
    localparam int ST_BRKIF = 7;
    localparam int ST_CC1OF = 9;
endpackage

// File: rtl/tmr_evgen_psc.sv
module tmr_evgen_psc #(
    parameter int PW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic          clr_i,
    input  logic [PW-1:0] div_i,
    output logic          tick_o
);
    logic [PW-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        tick_o  = 1'b0;
        if (clr_i) begin
            phase_d = '0;
        end else if (en_i) begin
            if (phase_q >= div_i) begin
                phase_d = '0;
                tick_o  = 1'b1;
            end else begin
                phase_d = phase_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) phase_q <= '0;
        else         phase_q <= phase_d;
    end

    // R4: a phase clear always restarts from zero
    a_r4_phase_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (phase_q == '0));
endmodule

// File: rtl/tmr_evgen_cnt.sv
module tmr_evgen_cnt
    import tmr_evgen_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          force_i,
    input  logic [1:0]    mode_i,
    input  logic [CW-1:0] arr_i,
    output logic [CW-1:0] cnt_o,
    output logic          upd_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          down;
    } cnt_st_t;

    cnt_st_t   st_d, st_q;
    cnt_mode_e mode;

    assign mode  = cnt_mode_e'(mode_i);
    assign cnt_o = st_q.cnt;

    always_comb begin
        st_d  = st_q;
        upd_o = 1'b0;
        if (force_i) begin
            upd_o     = 1'b1;
            st_d.down = 1'b0;
            st_d.cnt  = (mode == CNT_DOWN) ? arr_i : '0;
        end else if (tick_i) begin
            case (mode)
                CNT_DOWN: begin
                    if (st_q.cnt == '0) begin
                        st_d.cnt = arr_i;
                        upd_o    = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
                CNT_CENTER: begin
                    if (!st_q.down) begin
                        if (st_q.cnt >= arr_i) begin
                            st_d.cnt  = (arr_i == '0) ? '0 : arr_i - 1'b1;
                            st_d.down = 1'b1;
                            upd_o     = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end else begin
                        if (st_q.cnt == '0) begin
                            st_d.cnt  = (arr_i == '0) ? '0 : {{(CW-1){1'b0}}, 1'b1};
                            st_d.down = 1'b0;
                            upd_o     = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt - 1'b1;
                        end
                    end
                end
                default: begin
                    if (st_q.cnt >= arr_i) begin
                        st_d.cnt = '0;
                        upd_o    = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R3: forced update in down mode reloads
    a_r3_down_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (force_i && mode == CNT_DOWN) |=> (st_q.cnt == $past(arr_i)));

    // R7: plain up step
    a_r7_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!force_i && tick_i && mode == CNT_UP && st_q.cnt < arr_i)
        |=> (st_q.cnt == CW'($past(st_q.cnt) + 1'b1)));
endmodule

// File: rtl/tmr_evgen_cc1.sv
module tmr_evgen_cc1 #(
    parameter int CW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          fire_i,
    input  logic          in_mode_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          wr_i,
    input  logic [CW-1:0] wdata_i,
    input  logic          clr_if_i,
    input  logic          clr_of_i,
    output logic [CW-1:0] ccr_o,
    output logic          if_o,
    output logic          of_o
);
    typedef struct packed {
        logic [CW-1:0] ccr;
        logic          flag;
        logic          ovr;
    } cc_st_t;

    cc_st_t st_d, st_q;

    assign ccr_o = st_q.ccr;
    assign if_o  = st_q.flag;
    assign of_o  = st_q.ovr;

    always_comb begin
        st_d = st_q;
        if (wr_i)     st_d.ccr  = wdata_i;
        if (clr_if_i) st_d.flag = 1'b0;
        if (clr_of_i) st_d.ovr  = 1'b0;
        if (fire_i) begin
            st_d.flag = 1'b1;
            if (in_mode_i) begin
                st_d.ccr = cnt_i;
                if (st_q.flag) st_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R8: capture takes the counter value
    a_r8_capture_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire_i && in_mode_i) |=> (st_q.ccr == $past(cnt_i)));

    // R9: capture on a pending flag marks overcapture
    a_r9_overcapture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire_i && in_mode_i && st_q.flag) |=> st_q.ovr);

    // R10: output-mode event leaves the compare register alone
    a_r10_ccr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire_i && !in_mode_i && !wr_i) |=> $stable(st_q.ccr));
endmodule

// File: rtl/tmr_evgen_top.sv
module tmr_evgen_top
    import tmr_evgen_pkg::*;
#(
    parameter int CW = 16,
    parameter int PW = 16,
    parameter int RW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cnt_en_i,
    input  logic [PW-1:0] psc_div_i,
    input  logic [CW-1:0] arr_i,
    input  logic [1:0]    cnt_mode_i,
    input  logic          cc1_in_mode_i,
    input  logic          ccr_wr_i,
    input  logic [CW-1:0] ccr_wdata_i,
    input  logic          evg_wr_i,
    input  logic [RW-1:0] evg_wdata_i,
    input  logic          sts_wr_i,
    input  logic [RW-1:0] sts_wdata_i,
    input  logic          uie_i,
    input  logic          cc1_ie_i,
    input  logic          cc1_de_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] ccr_o,
    output logic [RW-1:0] sts_o,
    output logic          upd_irq_o,
    output logic          cc1_irq_o,
    output logic          cc1_dma_o,
    output logic          upd_evt_o,
    output logic          cc1_evt_o,
    output logic          com_evt_o,
    output logic          brk_evt_o
);
    typedef struct packed {
        logic uif;
        logic comif;
        logic brkif;
        logic p_upd;
        logic p_cc1;
        logic p_com;
        logic p_brk;
    } top_st_t;

    top_st_t st_d, st_q;

    logic f_upd, f_cc1, f_com, f_brk;
    logic tick, upd_any;
    logic cc1_if, cc1_of;
    logic unused_rsvd;

    assign f_upd = evg_wr_i & evg_wdata_i[EV_UPD];
    assign f_cc1 = evg_wr_i & evg_wdata_i[EV_CC1];
    assign f_com = evg_wr_i & evg_wdata_i[EV_COM];
    assign f_brk = evg_wr_i & evg_wdata_i[EV_BRK];

    assign unused_rsvd = ^{evg_wdata_i[RW-1:8], evg_wdata_i[6], evg_wdata_i[4:2],
                           sts_wdata_i[RW-1:10], sts_wdata_i[8], sts_wdata_i[6],
                           sts_wdata_i[4:2]};

    tmr_evgen_psc #(.PW(PW)) u_psc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (cnt_en_i),
        .clr_i  (f_upd),
        .div_i  (psc_div_i),
        .tick_o (tick)
    );

    tmr_evgen_cnt #(.CW(CW)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick),
        .force_i (f_upd),
        .mode_i  (cnt_mode_i),
        .arr_i   (arr_i),
        .cnt_o   (cnt_o),
        .upd_o   (upd_any)
    );

    tmr_evgen_cc1 #(.CW(CW)) u_cc1 (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fire_i    (f_cc1),
        .in_mode_i (cc1_in_mode_i),
        .cnt_i     (cnt_o),
        .wr_i      (ccr_wr_i),
        .wdata_i   (ccr_wdata_i),
        .clr_if_i  (sts_wr_i & ~sts_wdata_i[ST_CC1IF]),
        .clr_of_i  (sts_wr_i & ~sts_wdata_i[ST_CC1OF]),
        .ccr_o     (ccr_o),
        .if_o      (cc1_if),
        .of_o      (cc1_of)
    );

    always_comb begin
        st_d       = st_q;
        st_d.p_upd = upd_any;
        st_d.p_cc1 = f_cc1;
        st_d.p_com = f_com;
        st_d.p_brk = f_brk;
        if (sts_wr_i && !sts_wdata_i[ST_UIF])   st_d.uif   = 1'b0;
        if (sts_wr_i && !sts_wdata_i[ST_COMIF]) st_d.comif = 1'b0;
        if (sts_wr_i && !sts_wdata_i[ST_BRKIF]) st_d.brkif = 1'b0;
        if (upd_any) st_d.uif   = 1'b1;
        if (f_com)   st_d.comif = 1'b1;
        if (f_brk)   st_d.brkif = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        sts_o           = '0;
        sts_o[ST_UIF]   = st_q.uif;
        sts_o[ST_CC1IF] = cc1_if;
        sts_o[ST_COMIF] = st_q.comif;
        sts_o[ST_BRKIF] = st_q.brkif;
        sts_o[ST_CC1OF] = cc1_of;
    end

    assign upd_evt_o = st_q.p_upd;
    assign cc1_evt_o = st_q.p_cc1;
    assign com_evt_o = st_q.p_com;
    assign brk_evt_o = st_q.p_brk;
    assign upd_irq_o = st_q.uif & uie_i;
    assign cc1_irq_o = cc1_if & cc1_ie_i;
    assign cc1_dma_o = cc1_if & cc1_de_i;

    // R1: forced update is followed by an update pulse
    a_r1_upd_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        f_upd |=> upd_evt_o);

    // R5: an update pulse always has its flag raised
    a_r5_flag_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_evt_o |-> sts_o[ST_UIF]);

    // R12: control update pulse follows its strobe and nothing else
    a_r12_com_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        f_com |=> (com_evt_o && sts_o[ST_COMIF]));
    a_r12_com_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !f_com |=> !com_evt_o);
endmodule

// File: tb/tmr_evgen_top_tb_top.sv
module tmr_evgen_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] div = '0;
    logic [15:0] arr = '0;
    logic [1:0]  mode = '0;
    logic        in_mode = 1'b0;
    logic        ccr_wr = 1'b0;
    logic [15:0] ccr_wd = '0;
    logic        evg_wr = 1'b0;
    logic [15:0] evg_wd = '0;
    logic        sts_wr = 1'b0;
    logic [15:0] sts_wd = '0;
    logic        uie = 1'b0, ie = 1'b0, de = 1'b0;
    logic [15:0] cnt, ccr, sts;
    logic        upd_irq, cc1_irq, cc1_dma, upd_evt, cc1_evt, com_evt, brk_evt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_evgen_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(en), .psc_div_i(div), .arr_i(arr),
        .cnt_mode_i(mode), .cc1_in_mode_i(in_mode), .ccr_wr_i(ccr_wr),
        .ccr_wdata_i(ccr_wd), .evg_wr_i(evg_wr), .evg_wdata_i(evg_wd),
        .sts_wr_i(sts_wr), .sts_wdata_i(sts_wd), .uie_i(uie), .cc1_ie_i(ie),
        .cc1_de_i(de), .cnt_o(cnt), .ccr_o(ccr), .sts_o(sts),
        .upd_irq_o(upd_irq), .cc1_irq_o(cc1_irq), .cc1_dma_o(cc1_dma),
        .upd_evt_o(upd_evt), .cc1_evt_o(cc1_evt), .com_evt_o(com_evt),
        .brk_evt_o(brk_evt)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] arr;
        logic [7:0]  n;
        logic [15:0] exp_run;
        logic [15:0] exp_upd;
    } vec_t;

    // mode, reload, ticks, counter after ticks, counter after forced update
    localparam vec_t VECS [6] = '{
        '{2'd0, 16'd10, 8'd7, 16'd7,  16'd0},
        '{2'd0, 16'd5,  8'd8, 16'd2,  16'd0},
        '{2'd1, 16'd10, 8'd3, 16'd7,  16'd10},
        '{2'd1, 16'd4,  8'd7, 16'd2,  16'd4},
        '{2'd2, 16'd4,  8'd6, 16'd2,  16'd0},
        '{2'd2, 16'd3,  8'd9, 16'd3,  16'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ev(input logic [15:0] v);
        @(negedge clk); evg_wr = 1'b1; evg_wd = v;
        @(negedge clk); evg_wr = 1'b0; evg_wd = '0;
    endtask

    task automatic stw(input logic [15:0] v);
        @(negedge clk); sts_wr = 1'b1; sts_wd = v;
        @(negedge clk); sts_wr = 1'b0; sts_wd = '0;
    endtask

    task automatic run(input int n);
        @(negedge clk); en = 1'b1;
        repeat (n) @(negedge clk);
        en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R1 reset cnt", cnt, 0);
        chk("R13 reset sts", sts, 0);
        chk("R8 reset ccr", ccr, 0);
        chk("R1 reset pulses", {upd_evt, cc1_evt, com_evt, brk_evt}, 0);

        // table: natural counting then forced restart
        foreach (VECS[i]) begin
            mode = VECS[i].mode; arr = VECS[i].arr; div = '0;
            ev(16'h0001);
            stw(16'h0000);
            run(int'(VECS[i].n));
            chk("R7 natural count", cnt, VECS[i].exp_run);
            ev(16'h0001);
            chk("R3 forced restart", cnt, VECS[i].exp_upd);
            chk("R1 update pulse", upd_evt, 1);
            chk("R5 update flag", sts[0], 1);
        end

        // R3: center resumes upward after forced update
        mode = 2'd2; arr = 16'd4;
        run(1);
        chk("R3 center upward", cnt, 1);

        // R6: forced update in the cycle of the center top reversal
        ev(16'h0001);
        run(4);
        chk("R7 center at top", cnt, 4);
        @(negedge clk); en = 1'b1; evg_wr = 1'b1; evg_wd = 16'h0001;
        @(negedge clk); en = 1'b0; evg_wr = 1'b0; evg_wd = '0;
        chk("R6 forced value wins", cnt, 0);
        chk("R6 pulse present", upd_evt, 1);
        @(negedge clk);
        chk("R6 single pulse", upd_evt, 0);
        run(1);
        chk("R6 counts up after", cnt, 1);

        // R4: prescaler phase cleared, ratio kept
        mode = 2'd0; arr = 16'd100; div = 16'd3;
        run(2);
        ev(16'h0001);
        @(negedge clk); en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4 no early tick", cnt, 0);
        @(negedge clk);
        chk("R4 tick after div+1", cnt, 1);
        en = 1'b0; div = '0;

        // R5: update interrupt gating
        stw(16'h0000);
        ev(16'h0001);
        chk("R5 irq masked", upd_irq, 0);
        @(negedge clk); uie = 1'b1;
        @(negedge clk);
        chk("R5 irq enabled", upd_irq, 1);
        uie = 1'b0;

        // R8/R9/R11: forced captures in input mode
        stw(16'h0000);
        in_mode = 1'b1; ie = 1'b1;
        run(7);
        ev(16'h0002);
        chk("R8 captured value", ccr, 7);
        chk("R8 flag set", sts, 16'h0002);
        chk("R1 cc1 pulse", cc1_evt, 1);
        chk("R11 irq on", cc1_irq, 1);
        chk("R11 dma off", cc1_dma, 0);
        run(2);
        ev(16'h0002);
        chk("R9 second capture", ccr, 9);
        chk("R9 overcapture", sts, 16'h0202);
        @(negedge clk); de = 1'b1;
        @(negedge clk);
        chk("R11 dma on", cc1_dma, 1);
        de = 1'b0; ie = 1'b0;
        @(negedge clk);
        chk("R11 irq off", cc1_irq, 0);

        // R10: output mode
        in_mode = 1'b0;
        @(negedge clk); ccr_wr = 1'b1; ccr_wd = 16'h1234;
        @(negedge clk); ccr_wr = 1'b0; ccr_wd = '0;
        stw(16'h0000);
        ev(16'h0002);
        chk("R10 ccr kept", ccr, 16'h1234);
        chk("R10 flag set", sts, 16'h0002);
        chk("R10 cnt kept", cnt, 9);

        // R12: control update and break
        stw(16'h0000);
        ev(16'h00A0);
        chk("R12 pulses", {upd_evt, cc1_evt, com_evt, brk_evt}, 4'b0011);
        chk("R12 flags", sts, 16'h00A0);
        @(negedge clk);
        chk("R12 pulses end", {com_evt, brk_evt}, 0);

        // R13: clear by writing 0 only
        stw(16'hFFDF);
        chk("R13 clear one", sts, 16'h0080);

        // R13: set wins over clear
        @(negedge clk); evg_wr = 1'b1; evg_wd = 16'h0080; sts_wr = 1'b1; sts_wd = '0;
        @(negedge clk); evg_wr = 1'b0; evg_wd = '0; sts_wr = 1'b0;
        chk("R13 set wins", sts, 16'h0080);

        // R2: reserved and zero bits
        stw(16'h0000);
        ev(16'hFF5C);
        chk("R2 reserved pulses", {upd_evt, cc1_evt, com_evt, brk_evt}, 0);
        chk("R2 reserved sts", sts, 0);
        chk("R2 reserved cnt", cnt, 9);
        chk("R2 reserved ccr", ccr, 16'h1234);
        ev(16'h0000);
        chk("R2 zero word", {sts, cnt, upd_evt, cc1_evt, com_evt, brk_evt}, {16'h0, 16'd9, 4'b0});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule